// File: doc/BRIEF.md
# Flash Program/Erase Interlock Register

This block is the software-facing guard for flash programming and erasing. It holds one 8-bit control byte and a set of byte-wide block-select registers, all reached over a simple byte bus with a write strobe, an address and combinational read data. Each writable mode bit may only be set once a fixed chain of enable bits is already in place. The block only decides which bits may be set, and when. Timing, high-voltage sequencing and the array itself belong to other blocks.

The top bit of the control byte is a read-only flash-write-enable flag. It follows the inverted level of a write-protect pin, taken through a synchronizer, and a debug-mode input forces it to 1. Below the flag sit the following bits:
- a software enable bit;
- four setup and verify bits, which need the flag and the software enable;
- two action bits. Erase needs erase setup, and program needs program setup.

When an enable disappears, every bit that depends on it is cleared at the same clock edge. The mode bits drive dedicated strobe outputs. The block-select registers drive a flat select vector and stay at zero while the software enable is clear.

Top module: `flash_pe_guard`

## Requirements
- R1: Control byte bit 7 reads 1 when the write-protect pin is low and 0 when it is high. A pin change reaches bit 7 after two rising clock edges.
- R2: While the debug-mode input is high, bit 7 reads 1 at once, whatever the pin level.
- R3: After reset, the control byte reads 0 in bits 6..0, every block-select register reads 0 and all mode outputs are 0.
- R4: A write to address 0 sets bit 6 (software enable) only if bit 7 was 1 when the write was applied.
- R5: Bits 5 (erase setup), 4 (program setup), 3 (erase verify) and 2 (program verify) are set only if bits 7 and 6 were both 1 before the write.
- R6: Bit 1 (erase) is set only if bits 7, 6 and 5 were 1 before the write. Bit 0 (program) is set only if bits 7, 6 and 4 were 1 before the write.
- R7: Writing 0 to any writable bit clears it at the next edge, whatever the other bits hold.
- R8: In one write, bits whose chain is not met stay 0, while bits whose chain is met take the written value.
- R9: When a bit's enable drops, all of its dependents clear at the same edge. A flag of 0 clears bits 6..0 at the next edge. Erase is never 1 without erase setup, and program is never 1 without program setup.
- R10: Block-select register k sits at address k+1 and drives select bits [8k+7:8k]. A write to it is stored only if bit 6 was 1 before the write, and the stored value reads back. All of these registers are cleared at the edge where bit 6 becomes 0.
- R11: Address 3 reads 0, and writes to it change no state.
- R12: The outputs erase-setup, program-setup, erase-verify, program-verify, erase and program equal control bits 5, 4, 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wprot_pin | input | 1 | Write-protect pin, high means protected |
| dbg_mode | input | 1 | Debug mode, forces the write-enable flag to 1 |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_addr | input | ADDR_W | Byte address: 0 control, k+1 block-select k |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed byte |
| ers_setup | output | 1 | Erase setup mode |
| prg_setup | output | 1 | Program setup mode |
| ers_verify | output | 1 | Erase verify mode |
| prg_verify | output | 1 | Program verify mode |
| ers_go | output | 1 | Erase mode |
| prg_go | output | 1 | Program mode |
| blk_sel | output | 8*BLK_REGS | Block-select vector |

## Verification
Register writes and chain clears appear on the read data and the mode outputs after the single rising edge that applies the write. The bench drives each write on a falling edge and samples one falling edge later. A write-protect pin change reaches the flag after the second rising edge, and the clears it causes follow at the third, so the bench samples at each of those falling edges in turn. A debug-mode change reaches the flag at once, and the bench reads it in the same half cycle, before the next edge performs the clear.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int CTRL_W = 8;
  // bit positions inside the control byte (the read mux packs them in this order)
  localparam int B_FWE = 7;
  localparam int B_SWE = 6;
  localparam int B_ESU = 5;
  localparam int B_PSU = 4;
  localparam int B_EVF = 3;
  localparam int B_PVF = 2;
  localparam int B_ERS = 1;
  localparam int B_PRG = 0;

  typedef struct packed {
    logic swe;
    logic esu;
    logic psu;
    logic evf;
    logic pvf;
    logic ers;
    logic prg;
  } ctrl_t;
endpackage

// File: rtl/fpe_sync.sv
module fpe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fpe_ctrl_core.sv
module fpe_ctrl_core
  import flash_pe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwe,
  input  logic              wr_en,
  input  logic [CTRL_W-2:0] wdata,
  output ctrl_t             state_q,
  output logic              swe_nxt
);
  ctrl_t wr_v;
  ctrl_t state_d;
  logic  ld;

  // write qualification uses the state held before this write
  always_comb begin
    wr_v = state_q;
    if (wr_en) begin
      wr_v.swe = wdata[B_SWE] & fwe;
      wr_v.esu = wdata[B_ESU] & fwe & state_q.swe;
      wr_v.psu = wdata[B_PSU] & fwe & state_q.swe;
      wr_v.evf = wdata[B_EVF] & fwe & state_q.swe;
      wr_v.pvf = wdata[B_PVF] & fwe & state_q.swe;
      wr_v.ers = wdata[B_ERS] & fwe & state_q.swe & state_q.esu;
      wr_v.prg = wdata[B_PRG] & fwe & state_q.swe & state_q.psu;
    end
  end

  // dependency chain applied to the resulting values: drops cascade in one edge
  always_comb begin
    state_d.swe = wr_v.swe & fwe;
    state_d.esu = wr_v.esu & state_d.swe;
    state_d.psu = wr_v.psu & state_d.swe;
    state_d.evf = wr_v.evf & state_d.swe;
    state_d.pvf = wr_v.pvf & state_d.swe;
    state_d.ers = wr_v.ers & state_d.esu;
    state_d.prg = wr_v.prg & state_d.psu;
    ld          = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= '0;
    else if (ld) state_q <= state_d;
  end

  assign swe_nxt = state_d.swe;
endmodule

// File: rtl/fpe_blk_reg.sv
module fpe_blk_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         swe_q,
  input  logic         swe_nxt,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         ld;

  always_comb begin
    ld  = (wr_en & swe_q) | ~swe_nxt;
    q_d = swe_nxt ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= q_d;
  end
endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
  import flash_pe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BLK_REGS    = 2,
  parameter int ADDR_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wprot_pin,
  input  logic                    dbg_mode,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [CTRL_W-1:0]       bus_wdata,
  output logic [CTRL_W-1:0]       bus_rdata,
  output logic                    ers_setup,
  output logic                    prg_setup,
  output logic                    ers_verify,
  output logic                    prg_verify,
  output logic                    ers_go,
  output logic                    prg_go,
  output logic [CTRL_W*BLK_REGS-1:0] blk_sel
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic        rst_int_n;
  logic        wp_s;
  logic        fwe;
  logic        ctrl_hit;
  logic        swe_nxt;
  ctrl_t       ctrl_q;
  logic [CTRL_W-1:0] blk_q [BLK_REGS];

  fpe_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  // pin resets to the protected level until synchronized
  fpe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wp_sync (
    .clk(clk), .rst_n(rst_int_n), .d(wprot_pin), .q(wp_s)
  );

  assign fwe      = dbg_mode | ~wp_s;
  assign ctrl_hit = bus_wr && (bus_addr == CTRL_ADDR);

  fpe_ctrl_core u_core (
    .clk(clk), .rst_n(rst_int_n), .fwe(fwe), .wr_en(ctrl_hit),
    .wdata(bus_wdata[CTRL_W-2:0]), .state_q(ctrl_q), .swe_nxt(swe_nxt)
  );

  generate
    for (genvar k = 0; k < BLK_REGS; k++) begin : g_blk
      logic hit;
      assign hit = bus_wr && (bus_addr == ADDR_W'(k + 1));
      fpe_blk_reg #(.W(CTRL_W)) u_blk (
        .clk(clk), .rst_n(rst_int_n), .wr_en(hit), .wdata(bus_wdata),
        .swe_q(ctrl_q.swe), .swe_nxt(swe_nxt), .q(blk_q[k])
      );
      assign blk_sel[k*CTRL_W +: CTRL_W] = blk_q[k];
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) bus_rdata = {fwe, ctrl_q};
    for (int i = 0; i < BLK_REGS; i++) begin
      if (bus_addr == ADDR_W'(i + 1)) bus_rdata = blk_q[i];
    end
  end

  assign ers_setup  = ctrl_q.esu;
  assign prg_setup  = ctrl_q.psu;
  assign ers_verify = ctrl_q.evf;
  assign prg_verify = ctrl_q.pvf;
  assign ers_go     = ctrl_q.ers;
  assign prg_go     = ctrl_q.prg;
endmodule

// File: rtl/fpe_guard_chk.sv
module fpe_guard_chk #(
  parameter int ADDR_W = 2,
  parameter int SEL_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_mode,
  input logic              fwe,
  input logic              swe,
  input logic              esu,
  input logic              psu,
  input logic              evf,
  input logic              pvf,
  input logic              ers,
  input logic              prg,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wbit_swe,
  input logic              rd_flag,
  input logic [SEL_W-1:0]  blk_sel
);
  p_flag_dbg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && bus_addr == '0) |-> rd_flag);

  p_swe_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swe) |-> $past(fwe));

  p_setup_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(esu) || $rose(psu) || $rose(evf) || $rose(pvf)) |-> $past(fwe && swe));

  p_ers_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ers) |-> $past(fwe && swe && esu));

  p_prg_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prg) |-> $past(fwe && swe && psu));

  p_clear_swe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && !wbit_swe) |=> !swe);

  p_flag_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fwe |=> !swe);

  p_ers_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ers |-> esu);

  p_prg_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prg |-> psu);

  p_blk_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !swe |-> (blk_sel == '0));
endmodule

bind flash_pe_guard fpe_guard_chk #(.ADDR_W(ADDR_W), .SEL_W(CTRL_W*BLK_REGS)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .dbg_mode(dbg_mode), .fwe(fwe),
  .swe(ctrl_q.swe), .esu(ctrl_q.esu), .psu(ctrl_q.psu), .evf(ctrl_q.evf),
  .pvf(ctrl_q.pvf), .ers(ctrl_q.ers), .prg(ctrl_q.prg),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .wbit_swe(bus_wdata[6]),
  .rd_flag(bus_rdata[7]), .blk_sel(blk_sel)
);

// File: tb/sim_flash_pe_guard.sv
module sim_flash_pe_guard;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wprot_pin;
  logic        dbg_mode;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        ers_setup, prg_setup, ers_verify, prg_verify, ers_go, prg_go;
  logic [15:0] blk_sel;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  flash_pe_guard u0 (
    .clk(clk), .rst_n(rst_n), .wprot_pin(wprot_pin), .dbg_mode(dbg_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ers_setup(ers_setup), .prg_setup(prg_setup),
    .ers_verify(ers_verify), .prg_verify(prg_verify), .ers_go(ers_go),
    .prg_go(prg_go), .blk_sel(blk_sel)
  );

  // reference: qualification on old state, then chain cascade on new state
  function automatic logic [7:0] exp_ctrl(input logic [7:0] old, input logic [7:0] d, input logic f);
    logic [6:0] w;
    logic [6:0] n;
    w[6] = d[6] & f;
    for (int b = 2; b <= 5; b++) w[b] = d[b] & f & old[6];
    w[1] = d[1] & f & old[6] & old[5];
    w[0] = d[0] & f & old[6] & old[4];
    n[6] = w[6] & f;
    for (int b = 2; b <= 5; b++) n[b] = w[b] & n[6];
    n[1] = w[1] & n[5];
    n[0] = w[0] & n[4];
    return {f, n};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [7:0] modes();
    return {2'b00, ers_setup, prg_setup, ers_verify, prg_verify, ers_go, prg_go};
  endfunction

  task automatic build(input logic [7:0] base);
    wr(0, 8'h00);
    wr(0, 8'h40);
    wr(0, (base & 8'h7C) | 8'h40);
    wr(0, base);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] bases [10];
    bases = '{8'h00, 8'h40, 8'h60, 8'h50, 8'h48, 8'h44, 8'h7C, 8'h62, 8'h51, 8'h73};
    rst_n = 1'b0; wprot_pin = 1'b1; dbg_mode = 1'b0;
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    rd(0, v); check("R3 ctrl", {8'h0, v}, 16'h0000);
    rd(1, v); check("R3 blk0", {8'h0, v}, 16'h0000);
    rd(2, v); check("R3 blk1", {8'h0, v}, 16'h0000);
    check("R3 modes", {8'h0, modes()}, 16'h0000);
    check("R3 blk_sel", blk_sel, 16'h0000);

    // R1 synchronizer latency
    @(negedge clk); wprot_pin = 1'b0;
    @(negedge clk); rd(0, v); check("R1 after 1 edge", {8'h0, v}, 16'h0000);
    @(negedge clk); rd(0, v); check("R1 after 2 edges", {8'h0, v}, 16'h0080);

    // R4 R5 R6 R7 R8 R9 R12 sweep with flag set
    foreach (bases[i]) begin
      for (int d = 0; d < 256; d++) begin
        build(bases[i]);
        rd(0, v); check("R5/R6 base reached", {8'h0, v}, {8'h0, bases[i] | 8'h80});
        wr(0, 8'(d));
        rd(0, v);
        check("R4/R5/R6/R7/R8/R9 write", {8'h0, v}, {8'h0, exp_ctrl(bases[i], 8'(d), 1'b1)});
        check("R12 modes", {8'h0, modes()}, {8'h0, exp_ctrl(bases[i], 8'(d), 1'b1) & 8'h3F});
      end
    end

    // R9 cascade on flag drop, with a block-select register loaded
    build(8'h73);
    wr(0, 8'h53);
    rd(0, v); check("R9 erase follows setup", {8'h0, v}, 16'h00D1);
    wr(1, 8'h5A);
    @(negedge clk); wprot_pin = 1'b1;
    @(negedge clk); rd(0, v); check("R1 flag hold 1 edge", {8'h0, v}, 16'h00D1);
    @(negedge clk); rd(0, v); check("R1 flag drop 2 edges", {8'h0, v}, 16'h0051);
    @(negedge clk); rd(0, v); check("R9 cascade clear", {8'h0, v}, 16'h0000);
    check("R9 modes cleared", {8'h0, modes()}, 16'h0000);
    check("R10 blk cleared with enable", blk_sel, 16'h0000);

    // R4 R8 R10 flag clear: nothing can be set
    for (int d = 0; d < 256; d++) begin
      wr(0, 8'(d));
      rd(0, v); check("R4/R8 flag clear", {8'h0, v}, 16'h0000);
      wr(2, 8'(d));
      rd(2, v); check("R10 blocked blk", {8'h0, v}, 16'h0000);
    end

    // R2 debug forces flag
    dbg_mode = 1'b1;
    rd(0, v); check("R2 debug flag", {8'h0, v}, 16'h0080);
    wr(0, 8'h40);
    rd(0, v); check("R2 debug enables write", {8'h0, v}, 16'h00C0);
    @(negedge clk); dbg_mode = 1'b0;
    rd(0, v); check("R2 debug released", {8'h0, v}, 16'h0040);
    @(negedge clk); rd(0, v); check("R9 clear after release", {8'h0, v}, 16'h0000);

    // R10 block-select registers
    wprot_pin = 1'b0;
    repeat (3) @(negedge clk);
    wr(1, 8'hA5);
    rd(1, v); check("R10 blocked with enable 0", {8'h0, v}, 16'h0000);
    wr(0, 8'h40);
    for (int d = 0; d < 256; d++) begin
      wr(1, 8'(d));
      wr(2, ~8'(d));
      rd(1, v); check("R10 blk0 readback", {8'h0, v}, {8'h0, 8'(d)});
      rd(2, v); check("R10 blk1 readback", {8'h0, v}, {8'h0, ~8'(d)});
      check("R10 blk_sel", blk_sel, {~8'(d), 8'(d)});
    end

    // R11 unmapped address
    wr(1, 8'h11);
    wr(2, 8'h22);
    wr(3, 8'hFF);
    rd(3, v); check("R11 unmapped read", {8'h0, v}, 16'h0000);
    rd(0, v); check("R11 ctrl unchanged", {8'h0, v}, 16'h00C0);
    check("R11 blk unchanged", blk_sel, 16'h2211);

    // R7 clear enable clears block-select too
    wr(0, 8'h00);
    rd(0, v); check("R7 clear enable", {8'h0, v}, 16'h0080);
    check("R10 blk cleared by write", blk_sel, 16'h0000);

    finish_run();
  end
endmodule